// File: doc/BRIEF.md
# Flash Write Guard and Reset Sequencer

This block sits at the control-pin edge of a parallel NOR-style flash memory model. It brings the chip-enable, output-enable, write-enable and hardware-reset pins into the clock domain, passes each one through a glitch filter, and decides when a bus write is real. A write is committed only when chip-enable and write-enable are both low while output-enable stays high. Writes are not accepted during a supply-low lockout or straight after power-up while write-enable is still low.

A second part times the hardware reset pin. A low pulse counts only if it lasts a minimum number of cycles. A valid reset raises an abort request to the program/erase engine for a fixed internal-reset interval and then parks the block in standby. After the pin rises, a wake-up interval passes before reads may drive the bus again. The command decoder downstream uses the one-cycle write-commit pulse, the abort request, the output-drive permission and the ready flag. All timing is given as clock-cycle counts.

Top module: `flash_wguard`

## Requirements
- R1: A write commits only if the filtered chip-enable and write-enable are low (0) and the filtered output-enable is high (1) for the whole window. Output-enable going low inside the window cancels the write with no commit.
- R2: `wr_commit` is a single-cycle pulse. It fires once when the first of write-enable or chip-enable rises and ends a qualified window.
- R3: After synchronisation, a low pulse on write-enable or chip-enable shorter than GLITCH_CYC cycles starts no write and produces no commit.
- R4: While `lockout` is high, `ready` is low, `abort_req` is high and no write commits. After lockout clears, write-enable must be seen high before a new write counts.
- R5: If write-enable and chip-enable are already low when system reset ends, the first rising edge of write-enable does not commit.
- R6: A low pulse on `hwrst_n` shorter than RST_MIN_CYC cycles is ignored: no abort, and `ready` stays high.
- R7: When `hwrst_n` stays low for at least RST_MIN_CYC cycles, `abort_req` goes high for exactly IRST_CYC cycles. The block then stays in standby.
- R8: `oe_permit` is low while the filtered `hwrst_n` is low. No write commits during the reset sequence.
- R9: After `hwrst_n` rises, `oe_permit` and `ready` stay low for at least WAKE_CYC cycles, then both return high.
- R10: After system reset with idle pins, `ready` and `oe_permit` are high and `abort_req` and `wr_commit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| ce_n | input | 1 | Chip-enable pin, active low |
| oe_n | input | 1 | Output-enable pin, active low |
| we_n | input | 1 | Write-enable pin, active low |
| hwrst_n | input | 1 | Hardware reset pin, active low |
| lockout | input | 1 | Supply-low lockout indicator, active high |
| wr_commit | output | 1 | One-cycle qualified write pulse |
| abort_req | output | 1 | Terminate program/erase activity |
| oe_permit | output | 1 | Data outputs may be driven |
| ready | output | 1 | Read mode and accessible |

## Verification
The bench goes after the edges of each timed window. It sends reset pulses just short of and well past the minimum, write-enable glitches one cycle shorter than the filter, and samples output permission at the last cycle of wake-up. A design that counted reset time wrongly would abort on a short pulse, or would hold the abort for the wrong number of cycles. It also drives power-up and lockout release with write-enable already low, and ends a write with chip-enable first. A guard that missed these cases would commit a stray command from a held strobe, or would lose or double the commit pulse.

// File: rtl/fwg_pkg.sv
package fwg_pkg;
  // pin vector positions
  localparam int PIN_CE  = 0;
  localparam int PIN_OE  = 1;
  localparam int PIN_WE  = 2;
  localparam int PIN_RST = 3;
  localparam int NPINS   = 4;

  typedef enum logic [2:0] {
    SQ_RUN,
    SQ_ABORT,
    SQ_STANDBY,
    SQ_WAKE,
    SQ_LOCK
  } fwg_state_e;
endpackage

// File: rtl/fwg_sync2.sv
module fwg_sync2 #(
  parameter int          WIDTH = 1,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fwg_deglitch.sv
module fwg_deglitch #(
  parameter int          WIDTH     = 1,
  parameter int          GLITCH_CYC = 3,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CW = $clog2(GLITCH_CYC + 1);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [CW-1:0] cnt;
    logic          lvl;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
        lvl <= INIT[i];
      end else if (d[i] == lvl) begin
        cnt <= '0;
      end else if (cnt == CW'(GLITCH_CYC - 1)) begin
        cnt <= '0;
        lvl <= d[i];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

    assign q[i] = lvl;

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
      cnt < CW'(GLITCH_CYC));
  end
endmodule

// File: rtl/fwg_reset_seq.sv
module fwg_reset_seq
  import fwg_pkg::*;
#(
  parameter int RST_MIN_CYC = 25,
  parameter int IRST_CYC    = 50,
  parameter int WAKE_CYC    = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_low,
  input  logic lock,
  output logic abort_req,
  output logic oe_permit,
  output logic ready
);
  localparam int MAXC = (RST_MIN_CYC > IRST_CYC) ?
                        ((RST_MIN_CYC > WAKE_CYC) ? RST_MIN_CYC : WAKE_CYC) :
                        ((IRST_CYC > WAKE_CYC) ? IRST_CYC : WAKE_CYC);
  localparam int CW = $clog2(MAXC + 1);

  fwg_state_e    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_RUN;
      cnt   <= '0;
    end else begin
      unique case (state)
        SQ_RUN: begin
          if (lock) begin
            state <= SQ_LOCK;
            cnt   <= '0;
          end else if (pin_low) begin
            if (cnt == CW'(RST_MIN_CYC - 1)) begin
              state <= SQ_ABORT;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            cnt <= '0;
          end
        end
        SQ_ABORT: begin
          if (cnt == CW'(IRST_CYC - 1)) begin
            state <= SQ_STANDBY;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_STANDBY: begin
          cnt <= '0;
          if (!pin_low) state <= SQ_WAKE;
        end
        SQ_WAKE: begin
          if (pin_low) begin
            state <= SQ_STANDBY;
            cnt   <= '0;
          end else if (cnt == CW'(WAKE_CYC - 1)) begin
            state <= SQ_RUN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_LOCK: begin
          cnt <= '0;
          if (!lock) state <= SQ_RUN;
        end
        default: begin
          state <= SQ_RUN;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign abort_req = (state == SQ_ABORT) || (state == SQ_LOCK);
  assign oe_permit = ((state == SQ_RUN) || (state == SQ_LOCK)) && !pin_low;
  assign ready     = (state == SQ_RUN) && !lock;

  // R4
  abort_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    abort_req |-> !ready);

  // R8
  tristate_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    pin_low |-> !oe_permit);

  // R7
  abort_len_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_ABORT) |-> (cnt < CW'(IRST_CYC)));

  // R9
  wake_to_run_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_WAKE && !pin_low && cnt == CW'(WAKE_CYC - 1)) |=> ready || lock);
endmodule

// File: rtl/fwg_write_qual.sv
module fwg_write_qual (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ce_n_f,
  input  logic oe_n_f,
  input  logic we_n_f,
  output logic wr_commit
);
  logic armed;
  logic wcyc;
  logic end_edge;

  assign end_edge = we_n_f || ce_n_f;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      armed     <= 1'b0;
      wcyc      <= 1'b0;
      wr_commit <= 1'b0;
    end else begin
      if (we_n_f) armed <= 1'b1;
      wr_commit <= wcyc && oe_n_f && end_edge;
      if (wcyc) begin
        if (end_edge || !oe_n_f) wcyc <= 1'b0;
      end else if (armed && !ce_n_f && !we_n_f && oe_n_f) begin
        wcyc <= 1'b1;
      end
    end
  end

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> !wr_commit);

  // R4
  commit_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> $past(en));

  // R1
  commit_oe_high_chk: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> $past(oe_n_f));
endmodule

// File: rtl/flash_wguard.sv
module flash_wguard
  import fwg_pkg::*;
#(
  parameter int GLITCH_CYC  = 3,
  parameter int RST_MIN_CYC = 25,
  parameter int IRST_CYC    = 50,
  parameter int WAKE_CYC    = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic hwrst_n,
  input  logic lockout,
  output logic wr_commit,
  output logic abort_req,
  output logic oe_permit,
  output logic ready
);
  // strobes start as asserted so a held strobe at power-up is not trusted
  localparam logic [NPINS-1:0] PIN_INIT = 4'b1010;

  logic [NPINS-1:0] pins_raw, pins_s, pins_f;
  logic             lock_s;

  assign pins_raw[PIN_CE]  = ce_n;
  assign pins_raw[PIN_OE]  = oe_n;
  assign pins_raw[PIN_WE]  = we_n;
  assign pins_raw[PIN_RST] = hwrst_n;

  fwg_sync2 #(.WIDTH(NPINS), .INIT(PIN_INIT)) u_pin_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s));

  fwg_sync2 #(.WIDTH(1), .INIT(1'b0)) u_lock_sync (
    .clk(clk), .rst(rst), .d(lockout), .q(lock_s));

  fwg_deglitch #(.WIDTH(NPINS), .GLITCH_CYC(GLITCH_CYC), .INIT(PIN_INIT)) u_filt (
    .clk(clk), .rst(rst), .d(pins_s), .q(pins_f));

  fwg_reset_seq #(
    .RST_MIN_CYC(RST_MIN_CYC), .IRST_CYC(IRST_CYC), .WAKE_CYC(WAKE_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .pin_low(!pins_f[PIN_RST]), .lock(lock_s),
    .abort_req(abort_req), .oe_permit(oe_permit), .ready(ready));

  fwg_write_qual u_wq (
    .clk(clk), .rst(rst), .en(ready),
    .ce_n_f(pins_f[PIN_CE]), .oe_n_f(pins_f[PIN_OE]), .we_n_f(pins_f[PIN_WE]),
    .wr_commit(wr_commit));
endmodule

// File: tb/flash_wguard_test.sv
module flash_wguard_test;
  localparam int GLITCH_CYC  = 3;
  localparam int RST_MIN_CYC = 25;
  localparam int IRST_CYC    = 50;
  localparam int WAKE_CYC    = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b0, oe_n = 1'b1, we_n = 1'b0, hwrst_n = 1'b1, lockout = 1'b0;
  logic wr_commit, abort_req, oe_permit, ready;

  int n_vec = 0, n_bad = 0;
  int n_commit = 0, n_abort = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_wguard #(
    .GLITCH_CYC(GLITCH_CYC), .RST_MIN_CYC(RST_MIN_CYC),
    .IRST_CYC(IRST_CYC), .WAKE_CYC(WAKE_CYC)
  ) uut (.*);

  always @(posedge clk) if (!rst) begin
    if (wr_commit) n_commit++;
    if (abort_req) n_abort++;
  end

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic smp;
    @(negedge clk);
  endtask

  task automatic do_write(int hold, bit ce_first);
    ce_n = 0; we_n = 0; cyc(hold);
    if (ce_first) begin ce_n = 1; cyc(2); we_n = 1; end
    else begin we_n = 1; cyc(2); ce_n = 1; end
    cyc(12);
  endtask

  // R5 and R10
  task automatic t_powerup;
    int c0;
    cyc(5); rst = 0; cyc(12); smp;
    chk("R10 ready", ready, 1);
    chk("R10 oe_permit", oe_permit, 1);
    chk("R10 abort_req", abort_req, 0);
    chk("R10 wr_commit", wr_commit, 0);
    c0 = n_commit;
    we_n = 1; cyc(12); ce_n = 1; cyc(5); smp;
    chk("R5 held strobe not committed", n_commit - c0, 0);
  endtask

  // R1 and R2
  task automatic t_writes;
    int c0;
    c0 = n_commit; do_write(8, 0); smp;
    chk("R2 we-ended write one pulse", n_commit - c0, 1);
    c0 = n_commit; do_write(8, 1); smp;
    chk("R2 ce-ended write one pulse", n_commit - c0, 1);
    c0 = n_commit;
    ce_n = 0; we_n = 0; cyc(8); oe_n = 0; cyc(8); we_n = 1; ce_n = 1; cyc(12); oe_n = 1; cyc(8); smp;
    chk("R1 oe low cancels write", n_commit - c0, 0);
    c0 = n_commit;
    oe_n = 0; do_write(8, 0); oe_n = 1; cyc(8); smp;
    chk("R1 oe low inhibits write", n_commit - c0, 0);
  endtask

  // R3
  task automatic t_glitch;
    int c0;
    c0 = n_commit;
    ce_n = 0; cyc(8);
    we_n = 0; cyc(GLITCH_CYC - 1); we_n = 1; cyc(12);
    ce_n = 1; cyc(8); smp;
    chk("R3 short we pulse ignored", n_commit - c0, 0);
    c0 = n_commit;
    we_n = 0; cyc(8);
    ce_n = 0; cyc(GLITCH_CYC - 1); ce_n = 1; cyc(12);
    we_n = 1; cyc(8); smp;
    chk("R3 short ce pulse ignored", n_commit - c0, 0);
  endtask

  // R4
  task automatic t_lockout;
    int c0;
    lockout = 1; cyc(6); smp;
    chk("R4 ready low in lockout", ready, 0);
    chk("R4 abort high in lockout", abort_req, 1);
    c0 = n_commit; do_write(8, 0); smp;
    chk("R4 write ignored in lockout", n_commit - c0, 0);
    ce_n = 0; we_n = 0; cyc(8);
    lockout = 0; cyc(12);
    c0 = n_commit; we_n = 1; cyc(3); ce_n = 1; cyc(10); smp;
    chk("R4 held strobe after lockout", n_commit - c0, 0);
    chk("R4 ready back", ready, 1);
    c0 = n_commit; do_write(8, 0); smp;
    chk("R4 write accepted after lockout", n_commit - c0, 1);
  endtask

  // R6 to R9
  task automatic t_hwreset;
    int a0, c0;
    a0 = n_abort;
    hwrst_n = 0; cyc(RST_MIN_CYC - 3); hwrst_n = 1; cyc(RST_MIN_CYC + 10); smp;
    chk("R6 short reset no abort", n_abort - a0, 0);
    chk("R6 short reset ready", ready, 1);
    a0 = n_abort;
    hwrst_n = 0; cyc(20); smp;
    chk("R8 oe_permit low in reset", oe_permit, 0);
    cyc(RST_MIN_CYC + IRST_CYC + 20);
    smp;
    chk("R7 abort length", n_abort - a0, IRST_CYC);
    chk("R7 standby not ready", ready, 0);
    c0 = n_commit; do_write(8, 0); smp;
    chk("R8 no write in standby", n_commit - c0, 0);
    hwrst_n = 1; cyc(WAKE_CYC); smp;
    chk("R9 oe_permit held during wake", oe_permit, 0);
    chk("R9 ready held during wake", ready, 0);
    cyc(12); smp;
    chk("R9 oe_permit after wake", oe_permit, 1);
    chk("R9 ready after wake", ready, 1);
    c0 = n_commit; do_write(8, 0); smp;
    chk("R9 write after wake", n_commit - c0, 1);
  endtask

  initial begin
    t_powerup;
    t_writes;
    t_glitch;
    t_lockout;
    t_hwreset;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule